// File: doc/BRIEF.md
# Serial Memory Write-Protect and Commit Controller

This block is the permission and write-cycle keeper of an SPI serial memory slave. The serial front end shifts bits and decodes each opcode. It passes this block a command strobe, and at every moment it reports how far the current selection has got: the bit position inside the current byte and how many data bytes have arrived. This block holds the write enable latch, the write-in-progress flag, a protect-enable bit and two block-protect bits. When chip select returns high, it decides whether the pending write may take effect.

An array write that is accepted raises a one-cycle commit strobe toward the storage array. An accepted status write loads the nonvolatile status bits. Either kind starts a program cycle of fixed length, during which the block reports busy. The status byte can be read at any time, including during a program cycle.

The controller has three states. `ST_IDLE` waits for chip select to fall. `ST_SEL` records the first opcode of the selection. `ST_PROG` counts out the program cycle. The transitions are:
- **select**: `ST_IDLE` to `ST_SEL` on a chip-select fall.
- **release**: `ST_SEL` to `ST_IDLE` on a chip-select rise that does not start a write.
- **launch**: `ST_SEL` to `ST_PROG` on a chip-select rise that starts a write.
- **finish**: `ST_PROG` to `ST_IDLE` on the last program clock.

Top module: `wpc_ctrl`

## Requirements
- R1: After reset, `status_o` is 0x00, and both `busy_o` and `commit_o` are low.
- R2: The set-enable command (code 1) sets the write enable latch (status bit 1) only in the clock after chip select rises. While chip select stays low, the latch still reads 0.
- R3: The clear-enable command (code 2) clears the write enable latch when chip select rises.
- R4: An array write (code 4) is accepted when the latch is set, `bit_phase` is 0 and `data_bytes` is nonzero at the chip-select rise. In the clock after that rise, `commit_o` pulses for exactly one cycle and `busy_o` goes high.
- R5: An array write whose chip-select rise comes with `bit_phase` nonzero, or with `data_bytes` zero, does not commit. It starts no program cycle and leaves the status byte unchanged.
- R6: A write (code 3 or 4) attempted while the write enable latch is clear is ignored. There is no commit, no busy, and the status byte is unchanged.
- R7: `busy_o` and status bit 0 stay high for exactly PROG_CYCLES clocks. The write enable latch reads 0 once they fall.
- R8: An accepted status write (code 3) copies `stat_wdata` bits 7, 3 and 2 into status bits 7 (protect-enable), 3 and 2 (block-protect). It discards the other data bits, starts a program cycle, and does not pulse `commit_o`. Status bits 6:4 always read 0.
- R9: When protect-enable is 1 and `wp_n` is low at the chip-select rise, a status write is blocked. No program cycle starts, and the status byte, including the write enable latch, is unchanged.
- R10: When protect-enable is 0, a low `wp_n` has no effect, and a status write is accepted.
- R11: A low `wp_n` never blocks an array write, whatever the value of protect-enable.
- R12: During a program cycle, chip select toggling and `wp_n` falling do not shorten the cycle. Commands in a selection that began during the cycle are ignored. The status byte stays readable and shows write-in-progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_stb | input | 1 | One-cycle pulse when an opcode has been decoded |
| cmd_code | input | 3 | Decoded opcode: 1 set-enable, 2 clear-enable, 3 status write, 4 array write, 5 other |
| bit_phase | input | PHASE_W (3) | Bits received into the current byte; 0 means on a byte boundary |
| data_bytes | input | CNT_W (7) | Whole data bytes received after the command header |
| stat_wdata | input | 8 | Status data byte received in a status write |
| status_o | output | 8 | Status byte: bit 7 protect-enable, 3:2 block-protect, 1 write enable latch, 0 write in progress |
| commit_o | output | 1 | One-cycle strobe that commits an array write |
| busy_o | output | 1 | High for the whole program cycle |

## Verification
A latch that is set too early or cleared at the wrong moment shows up on status bit 1 in the first clock after the chip-select rise. The same error also turns a later write into an unexpected commit pulse, or a missing one. A program counter that is off by one changes the length of the `busy_o` high run, so counting that run exposes it. A protect decision made the wrong way shows within one clock, either as a spurious busy rise or as status bits that fail to move. The scoreboard ties every commit pulse to the exact cycle after the chip-select rise that should have caused it.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_SET_WE   = 3'd1,
        CMD_CLR_WE   = 3'd2,
        CMD_WR_STAT  = 3'd3,
        CMD_WR_ARRAY = 3'd4,
        CMD_OTHER    = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_PROG = 2'd2
    } state_e;

    // status bits that a status write may load
    localparam logic [7:0] NV_KEEP_MASK = 8'b1000_1100;

endpackage

// File: rtl/wpc_cs_edge.sv
module wpc_cs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_fall,
    output logic cs_rise
);

    logic cs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
        end else begin
            cs_q <= cs_n;
        end
    end

    assign cs_fall = cs_q & ~cs_n;
    assign cs_rise = ~cs_q & cs_n;

endmodule

// File: rtl/wpc_gate.sv
module wpc_gate
    import wpc_pkg::*;
#(
    parameter int PHASE_W = 3,
    parameter int CNT_W   = 7
) (
    input  cmd_e               pend,
    input  logic               wel,
    input  logic               wpen,
    input  logic               wp_n,
    input  logic [PHASE_W-1:0] bit_phase,
    input  logic [CNT_W-1:0]   data_bytes,
    output logic               go_array,
    output logic               go_status,
    output logic               set_wel,
    output logic               clr_wel
);

    logic framed;
    logic locked;

    always_comb begin
        framed    = (bit_phase == '0) && (data_bytes != '0);
        locked    = wpen && !wp_n;
        go_array  = (pend == CMD_WR_ARRAY) && wel && framed;
        go_status = (pend == CMD_WR_STAT) && wel && framed && !locked;
        set_wel   = (pend == CMD_SET_WE);
        clr_wel   = (pend == CMD_CLR_WE);
    end

endmodule

// File: rtl/wpc_prog_timer.sv
module wpc_prog_timer #(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);

    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign last = busy && (cnt == '0);

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int PROG_CYCLES = 40,
    parameter int BYTE_BITS   = 8,
    parameter int PHASE_W     = $clog2(BYTE_BITS),
    parameter int CNT_W       = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               wp_n,
    input  logic               cmd_stb,
    input  logic [2:0]         cmd_code,
    input  logic [PHASE_W-1:0] bit_phase,
    input  logic [CNT_W-1:0]   data_bytes,
    input  logic [7:0]         stat_wdata,
    output logic [7:0]         status_o,
    output logic               commit_o,
    output logic               busy_o
);

    state_e     state_q, state_d;
    cmd_e       pend_q;
    logic       wel_q;
    logic [7:0] nv_q;
    logic       commit_q;

    logic cs_fall, cs_rise;
    logic go_array, go_status, set_wel, clr_wel;
    logic start, prog_busy, prog_last;

    wpc_cs_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise)
    );

    wpc_gate #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_gate (
        .pend       (pend_q),
        .wel        (wel_q),
        .wpen       (nv_q[7]),
        .wp_n       (wp_n),
        .bit_phase  (bit_phase),
        .data_bytes (data_bytes),
        .go_array   (go_array),
        .go_status  (go_status),
        .set_wel    (set_wel),
        .clr_wel    (clr_wel)
    );

    wpc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (prog_busy),
        .last  (prog_last)
    );

    assign start = (state_q == ST_SEL) && cs_rise && (go_array || go_status);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall)   state_d = ST_SEL;
            ST_SEL:  if (cs_rise)   state_d = start ? ST_PROG : ST_IDLE;
            ST_PROG: if (prog_last) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and held state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= CMD_NONE;
            wel_q    <= 1'b0;
            nv_q     <= 8'h00;
            commit_q <= 1'b0;
        end else begin
            commit_q <= start && go_array;
            if (prog_last) begin
                wel_q <= 1'b0;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) pend_q <= CMD_NONE;
                end
                ST_SEL: begin
                    if (cs_rise) begin
                        pend_q <= CMD_NONE;
                        if (set_wel) wel_q <= 1'b1;
                        if (clr_wel) wel_q <= 1'b0;
                        if (start && go_status) nv_q <= stat_wdata & NV_KEEP_MASK;
                    end else if (cmd_stb && pend_q == CMD_NONE) begin
                        pend_q <= cmd_e'(cmd_code);
                    end
                end
                ST_PROG: begin
                    pend_q <= CMD_NONE;
                end
                default: pend_q <= CMD_NONE;
            endcase
        end
    end

    assign status_o = nv_q | {6'b0, wel_q, prog_busy};
    assign commit_o = commit_q;
    assign busy_o   = prog_busy;

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int PROG_CYCLES = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [7:0] status_o,
    input logic       commit_o,
    input logic       busy_o
);

    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= 0;
        else if (busy_o) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    assert_commit_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> busy_o);

    assert_busy_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_n));

    assert_wel_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> $past(cs_n));

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == PROG_CYCLES));

    assert_wel_clear_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[1]);

    assert_nv_only_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o[7:2]) |-> $rose(busy_o));

    assert_status_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(status_o[7:1]));

endmodule

bind wpc_ctrl wpc_checker #(.PROG_CYCLES(PROG_CYCLES)) u_wpc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .status_o (status_o),
    .commit_o (commit_o),
    .busy_o   (busy_o)
);

// File: tb/wpc_ctrl_tb.sv
`timescale 1ns/1ps
module wpc_ctrl_tb_top;

    localparam int P = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wp_n = 1'b1;
    logic       cmd_stb = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [2:0] bit_phase = 3'd0;
    logic [6:0] data_bytes = 7'd0;
    logic [7:0] stat_wdata = 8'h00;
    logic [7:0] status_o;
    logic       commit_o;
    logic       busy_o;

    int tests = 0;
    int fails = 0;
    int nidx  = 0;
    int exp_q[$];
    bit done  = 0;

    always #10 clk = ~clk;

    wpc_ctrl #(.PROG_CYCLES(P)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wp_n       (wp_n),
        .cmd_stb    (cmd_stb),
        .cmd_code   (cmd_code),
        .bit_phase  (bit_phase),
        .data_bytes (data_bytes),
        .stat_wdata (stat_wdata),
        .status_o   (status_o),
        .commit_o   (commit_o),
        .busy_o     (busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: compares commit pulses against the expected-cycle queue (R4)
    always @(negedge clk) begin
        nidx++;
        if (rst_n && !done) begin
            while (exp_q.size() > 0 && exp_q[0] < nidx) begin
                chk(0, "R4 missed commit", 0, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (commit_o) begin
                if (exp_q.size() > 0 && exp_q[0] == nidx) begin
                    void'(exp_q.pop_front());
                    chk(1, "R4 commit", 1, 1);
                end else begin
                    chk(0, "R4 unexpected commit", nidx, 0);
                end
            end
        end
    end

    // driver: one complete selection, ending one sample after the rise
    task automatic sel(input logic [2:0] code, input int phase, input int nb,
                       input logic [7:0] wd, input bit exp_commit);
        @(negedge clk); #1 cs_n = 1'b0;
        @(negedge clk); #1 cmd_stb = 1'b1; cmd_code = code;
        @(negedge clk); #1 cmd_stb = 1'b0; bit_phase = 3'(phase);
        data_bytes = 7'(nb); stat_wdata = wd;
        @(negedge clk); #1 cs_n = 1'b1;
        if (exp_commit) exp_q.push_back(nidx + 1);
        @(negedge clk); #1;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1
        chk(status_o == 8'h00, "R1 status", status_o, 8'h00);
        chk(!busy_o && !commit_o, "R1 busy/commit", {busy_o, commit_o}, 0);

        // R6: array write and status write without the latch
        sel(3'd4, 0, 1, 8'h00, 0);
        chk(status_o == 8'h00 && !busy_o, "R6 array ignored", status_o, 8'h00);
        sel(3'd3, 0, 1, 8'h8C, 0);
        chk(status_o == 8'h00 && !busy_o, "R6 status ignored", status_o, 8'h00);

        // R2: latch not visible while selected
        @(negedge clk); #1 cs_n = 1'b0;
        @(negedge clk); #1 cmd_stb = 1'b1; cmd_code = 3'd1;
        @(negedge clk); #1 cmd_stb = 1'b0;
        @(negedge clk); #1;
        chk(status_o[1] == 1'b0, "R2 latch during selection", status_o, 8'h00);
        cs_n = 1'b1;
        @(negedge clk); #1;
        chk(status_o == 8'h02, "R2 latch after rise", status_o, 8'h02);

        // R5: misframed array writes
        sel(3'd4, 3, 2, 8'h00, 0);
        chk(status_o == 8'h02 && !busy_o, "R5 mid-byte rise", status_o, 8'h02);
        sel(3'd4, 0, 0, 8'h00, 0);
        chk(status_o == 8'h02 && !busy_o, "R5 no data byte", status_o, 8'h02);

        // R3
        sel(3'd2, 0, 0, 8'h00, 0);
        chk(status_o == 8'h00, "R3 clear latch", status_o, 8'h00);

        // R4 / R7: accepted array write
        sel(3'd1, 0, 0, 8'h00, 0);
        sel(3'd4, 0, 3, 8'h00, 1);
        chk(busy_o == 1'b1, "R4 busy after rise", busy_o, 1);
        chk(status_o == 8'h03, "R4 status in cycle", status_o, 8'h03);
        wait_idle(n);
        chk(n == P, "R7 busy length", n, P);
        chk(status_o == 8'h00, "R7 latch cleared", status_o, 8'h00);

        // R12: activity during a program cycle
        sel(3'd1, 0, 0, 8'h00, 0);
        sel(3'd4, 0, 1, 8'h00, 1);
        sel(3'd1, 0, 0, 8'h00, 0);
        wp_n = 1'b0;
        chk(status_o == 8'h03 && busy_o, "R12 readable while busy", status_o, 8'h03);
        wait_idle(n);
        chk(n == P - 5, "R12 cycle not shortened", n, P - 5);
        chk(status_o == 8'h00, "R12 busy-time command ignored", status_o, 8'h00);

        // R10 / R8: protect-enable 0, wp_n low, status write accepted
        sel(3'd1, 0, 0, 8'h00, 0);
        sel(3'd3, 0, 1, 8'hFF, 0);
        chk(status_o == 8'h8F && busy_o, "R10 status write with wp_n low", status_o, 8'h8F);
        wait_idle(n);
        chk(status_o == 8'h8C, "R8 status loaded", status_o, 8'h8C);

        // R9: protect-enable 1 and wp_n low blocks
        sel(3'd1, 0, 0, 8'h00, 0);
        sel(3'd3, 0, 1, 8'h00, 0);
        chk(status_o == 8'h8E && !busy_o, "R9 status write blocked", status_o, 8'h8E);

        // R11: array write unaffected by wp_n
        sel(3'd4, 0, 2, 8'h00, 1);
        chk(busy_o == 1'b1, "R11 array write proceeds", busy_o, 1);
        wait_idle(n);
        chk(status_o == 8'h8C, "R11 after cycle", status_o, 8'h8C);

        // R8: wp_n high again, clear protect-enable, keep one block-protect bit
        wp_n = 1'b1;
        sel(3'd1, 0, 0, 8'h00, 0);
        sel(3'd3, 0, 1, 8'h74, 0);
        wait_idle(n);
        chk(status_o == 8'h04, "R8 masked status write", status_o, 8'h04);

        repeat (3) @(negedge clk);
        #1;
        chk(exp_q.size() == 0, "R4 pending commits", exp_q.size(), 0);
        finish_run();
    end

endmodule